// File: doc/BRIEF.md
# One-Hot Majority Vote Selector

This block is the last stage of a lane-parallel nearest-anchor classifier. Each of P search lanes delivers a C-bit one-hot word naming the class it voted for. When a valid strobe arrives with all lane words, the block forms one vote count per class by summing that class's bit across the lanes, and registers the C counts. A serial scan then visits the counts one per cycle, carrying the best count seen so far and the class index it belongs to. When the scan has visited the last class, the carried index is presented with a one-cycle valid strobe.

While a scan runs, the block drops its ready output. The upstream lanes, which need about K cycles per query anyway, wait on it instead of losing a vote set. Lane words are packed into one flat input bus: lane p holds bits [p*C +: C], and bit c of a lane word is class c.

Top module: `onehot_vote_sel`

## Requirements
- R1: After reset is released and before any vote set is accepted, out_valid is 0 and in_ready is 1.
- R2: A vote set is accepted on a rising clock edge where in_valid and in_ready are both 1. The count for class c is the number of lanes p whose bit p*C+c is set.
- R3: The reported out_class is a class whose count is the largest of all C counts.
- R4: When several classes share the largest count, out_class is the lowest of their indices.
- R5: Each accepted vote set produces exactly one out_valid pulse, one clock cycle long.
- R6: out_valid rises on the (C-1)th rising edge after the accepting edge, one edge for each comparison of the scan.
- R7: in_ready is 0 from the accepting edge until out_valid rises. A strobe on in_valid while in_ready is 0 changes neither the result nor the number of out_valid pulses.
- R8: in_ready is 1 in the cycle where out_valid is 1, so vote sets fed back to back are accepted every C cycles.
- R9: A vote set with no bit set at all reports class 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A lane vote set is presented |
| in_votes | input | P*C | Lane vote words; lane p holds bits [p*C +: C] |
| in_ready | output | 1 | High when no scan is in progress |
| out_valid | output | 1 | One-cycle strobe marking a result |
| out_class | output | $clog2(C) | Winning class index |

## Verification
The hardest case to reach from the ports is a strobe that arrives during a scan. It carries a different vote set, and a faulty design would either take it or let it overwrite the held counts. The stimulus raises in_valid for one cycle in the middle of a scan, with words that vote for another class. It then checks that the original winner comes out and that no second pulse follows. Tie patterns are built on purpose: two groups of lanes split evenly, and a winner at the highest class index, which is only settled by the final comparison. Random one-hot sets drawn from a narrow class range create further ties.

// File: rtl/vote_pkg.sv
package vote_pkg;

  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_t;

endpackage

// File: rtl/vote_tally.sv
module vote_tally #(
  parameter int P  = 8,
  parameter int C  = 10,
  parameter int CW = 4
) (
  input  logic [P*C-1:0]  votes,
  output logic [C*CW-1:0] counts
);

  function automatic logic [CW-1:0] column_sum(input logic [P*C-1:0] v, input int cls);
    logic [CW-1:0] acc;
    acc = '0;
    for (int lane = 0; lane < P; lane++) begin
      acc = acc + CW'(v[lane*C + cls]);
    end
    return acc;
  endfunction

  for (genvar g = 0; g < C; g++) begin : g_class
    assign counts[g*CW +: CW] = column_sum(votes, g);
  end

endmodule

// File: rtl/vote_scan.sv
module vote_scan
  import vote_pkg::*;
#(
  parameter int C  = 10,
  parameter int CW = 4,
  parameter int IW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [C*CW-1:0] cnt_in,
  output logic           busy,
  output logic [C*CW-1:0] cnt_held,
  output logic           done,
  output logic [IW-1:0]  win_idx
);

  localparam logic [IW-1:0] LAST = IW'(C - 1);

  scan_state_t    state;
  logic [C*CW-1:0] cnt_q;
  logic [CW-1:0]  best_cnt;
  logic [IW-1:0]  best_idx;
  logic [IW-1:0]  ptr;
  logic [CW-1:0]  cur_cnt;
  logic           take;

  function automatic logic beats(input logic [CW-1:0] cand, input logic [CW-1:0] held);
    return cand > held;
  endfunction

  assign cur_cnt = cnt_q[ptr*CW +: CW];
  assign take    = beats(cur_cnt, best_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SCAN_IDLE;
      cnt_q    <= '0;
      best_cnt <= '0;
      best_idx <= '0;
      ptr      <= '0;
      done     <= 1'b0;
      win_idx  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SCAN_IDLE: begin
          if (load) begin
            cnt_q    <= cnt_in;
            best_cnt <= cnt_in[CW-1:0];
            best_idx <= '0;
            ptr      <= IW'(1);
            state    <= SCAN_RUN;
          end
        end
        SCAN_RUN: begin
          if (take) begin
            best_cnt <= cur_cnt;
            best_idx <= ptr;
          end
          if (ptr == LAST) begin
            state   <= SCAN_IDLE;
            done    <= 1'b1;
            win_idx <= take ? ptr : best_idx;
          end else begin
            ptr <= ptr + IW'(1);
          end
        end
        default: state <= SCAN_IDLE;
      endcase
    end
  end

  assign busy     = (state == SCAN_RUN);
  assign cnt_held = cnt_q;

endmodule

// File: rtl/onehot_vote_sel.sv
module onehot_vote_sel #(
  parameter int P = 8,
  parameter int C = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [P*C-1:0]       in_votes,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic [$clog2(C)-1:0] out_class
);

  localparam int CW = $clog2(P + 1);
  localparam int IW = $clog2(C);

  logic            accept;
  logic            scan_busy;
  logic [C*CW-1:0] cnt_comb;
  logic [C*CW-1:0] cnt_flat;

  assign accept = in_valid && in_ready;

  vote_tally #(.P(P), .C(C), .CW(CW)) u_tally (
    .votes  (in_votes),
    .counts (cnt_comb)
  );

  vote_scan #(.C(C), .CW(CW), .IW(IW)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .cnt_in   (cnt_comb),
    .busy     (scan_busy),
    .cnt_held (cnt_flat),
    .done     (out_valid),
    .win_idx  (out_class)
  );

  assign in_ready = !scan_busy;

endmodule

// File: rtl/vote_sel_checker.sv
module vote_sel_checker #(
  parameter int P = 8,
  parameter int C = 10
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_valid,
  input logic                          in_ready,
  input logic                          out_valid,
  input logic [$clog2(C)-1:0]          out_class,
  input logic [C*$clog2(P+1)-1:0]      cnt_flat
);

  localparam int CW = $clog2(P + 1);

  logic [15:0] since;
  logic        took;

  assign took = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since <= '1;
    else if (took)           since <= '0;
    else if (since != '1)    since <= since + 16'd1;
  end

  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 16'hFFFF) |-> in_ready);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (since == 16'(C - 1)));

  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> !in_ready);

  a_r8_ready_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

  a_r3_class_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_class) < C));

  for (genvar g = 0; g < C; g++) begin : g_cls
    a_r3_is_max: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (cnt_flat[g*CW +: CW] <= cnt_flat[out_class*CW +: CW]));
    a_r4_low_tie: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (g < int'(out_class))) |->
        (cnt_flat[g*CW +: CW] < cnt_flat[out_class*CW +: CW]));
  end

endmodule

bind onehot_vote_sel vote_sel_checker #(.P(P), .C(C)) u_vote_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_class (out_class),
  .cnt_flat  (cnt_flat)
);

// File: tb/test_onehot_vote_sel.sv
module test_onehot_vote_sel;

  localparam int NP     = 8;
  localparam int NC     = 10;
  localparam int IW     = $clog2(NC);
  localparam int W      = NP * NC;
  localparam int CLK_NS = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_votes = '0;
  logic          in_ready;
  logic          out_valid;
  logic [IW-1:0] out_class;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  onehot_vote_sel #(.P(NP), .C(NC)) i_onehot_vote_sel (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_votes(in_votes),
    .in_ready(in_ready), .out_valid(out_valid), .out_class(out_class)
  );

  function automatic int ref_win(input logic [W-1:0] v);
    int tally [NC];
    int best;
    for (int c = 0; c < NC; c++) tally[c] = 0;
    for (int l = 0; l < NP; l++)
      for (int c = 0; c < NC; c++)
        if (v[l*NC + c]) tally[c]++;
    best = 0;
    for (int c = 1; c < NC; c++)
      if (tally[c] > tally[best]) best = c;
    return best;
  endfunction

  function automatic logic [W-1:0] put_vote(input logic [W-1:0] v, input int lane, input int cls);
    logic [W-1:0] r;
    r = v;
    r[lane*NC + cls] = 1'b1;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vote(input logic [W-1:0] v, input bit intrude, input bit tail);
    int  exp;
    bit  early;
    logic [W-1:0] alt;
    exp   = ref_win(v);
    early = 1'b0;
    alt   = '0;
    for (int l = 0; l < NP; l++) alt = put_vote(alt, l, (exp + 1) % NC);
    check(in_ready === 1'b1, "R8 ready before offer", int'(in_ready), 1);
    in_valid = 1'b1;
    in_votes = v;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    in_votes = '0;
    for (int k = 1; k <= NC - 1; k++) begin
      if (out_valid !== 1'b0 || in_ready !== 1'b0) early = 1'b1;
      if (intrude && k == 1) begin in_valid = 1'b1; in_votes = alt; end
      if (intrude && k == 2) begin in_valid = 1'b0; in_votes = '0; end
      @(posedge clk); @(negedge clk);
    end
    in_valid = 1'b0;
    check(!early, "R7 busy and no early result during scan", int'(early), 0);
    check(out_valid === 1'b1, "R6 result after C-1 edges", int'(out_valid), 1);
    check(int'(out_class) == exp, "R2/R3/R4 winning class", int'(out_class), exp);
    check(in_ready === 1'b1, "R8 ready with result", int'(in_ready), 1);
    if (tail) begin
      @(posedge clk); @(negedge clk);
      check(out_valid === 1'b0, "R5 one-cycle pulse", int'(out_valid), 0);
    end
    if (intrude) begin
      bit extra;
      extra = 1'b0;
      for (int k = 0; k < 2*NC; k++) begin
        @(posedge clk); @(negedge clk);
        if (out_valid !== 1'b0) extra = 1'b1;
      end
      check(!extra, "R7 held-off strobe adds no result", int'(extra), 0);
    end
  endtask

  initial begin
    logic [W-1:0] v;
    int unused_seed;
    unused_seed = $urandom(32'd4711);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready === 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    // R9: empty vote set
    run_vote('0, 1'b0, 1'b1);
    // R3: all lanes vote for the highest class
    v = '0;
    for (int l = 0; l < NP; l++) v = put_vote(v, l, NC - 1);
    run_vote(v, 1'b0, 1'b1);
    // R4: even split between class 5 and class 2 goes to class 2
    v = '0;
    for (int l = 0; l < NP; l++) v = put_vote(v, l, (l < NP/2) ? 5 : 2);
    run_vote(v, 1'b0, 1'b1);
    // R4: tie at class 0 and class NC-1
    v = '0;
    for (int l = 0; l < NP; l++) v = put_vote(v, l, (l % 2 == 0) ? NC - 1 : 0);
    run_vote(v, 1'b0, 1'b1);
    // R2: single lane leads by one vote
    v = '0;
    for (int l = 0; l < NP; l++) v = put_vote(v, l, (l < 3) ? 7 : l % 3);
    run_vote(v, 1'b0, 1'b1);
    // R7: strobe while busy is ignored
    v = '0;
    for (int l = 0; l < NP; l++) v = put_vote(v, l, 4);
    run_vote(v, 1'b1, 1'b0);
    // R8: back-to-back sets, each offered in the result cycle
    for (int i = 0; i < 4; i++) begin
      v = '0;
      for (int l = 0; l < NP; l++) v = put_vote(v, l, (i + l) % 3 + i);
      run_vote(v, 1'b0, i == 3);
    end
    // random one-hot sets, narrow ranges for more ties
    for (int i = 0; i < 40; i++) begin
      int span;
      span = (i % 2 == 0) ? 3 : NC;
      v = '0;
      for (int l = 0; l < NP; l++) v = put_vote(v, l, int'($urandom_range(span - 1, 0)));
      run_vote(v, 1'b0, i % 3 == 0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule